// File: doc/BRIEF.md
# Precision-time event capture register

This block is a one-slot holding register. It keeps the sequence number and the 64-bit time value of one timing event packet until host software reads them and frees the slot. A packet classifier upstream pulses a capture strobe and presents a 16-bit sequence number. A free-running time counter supplies the current 64-bit time. Software uses a small word-wide register port to read the slot, and writes to that port to release it.

There are two build variants, chosen by a parameter. In the receive variant, one strobe records the sequence number and the time together. In the transmit variant, capture happens in two steps. The strobe stores the sequence number and marks the slot as waiting. The time is latched later, when a separate departure strobe arrives. The transmit variant also stores whether software or hardware requested the capture.

Only one event can be held at a time. Strobes that arrive while the slot is occupied are discarded, and a sticky flag records that at least one was lost.

Top module: `ptp_ts_holdbuf`

## Requirements
- R1: After reset, the status word, both time words and the word at address 3 all read zero.
- R2: In the receive variant, a capture strobe on an empty slot loads the sequence number into status bits [15:0], loads the time input into the time register and sets the ready flag (status bit 16). The new contents can be read in the cycle after the clock edge.
- R3: The register port decodes four addresses. Address 0 is the status word, address 1 is time bits [31:0], address 2 is time bits [63:32], and address 3 always reads zero. Both time halves come from the same sample of the time input.
- R4: A capture strobe that arrives while the slot is ready or waiting changes neither the stored sequence number nor the stored time.
- R5: Each discarded strobe sets the loss flag (status bit 19). The flag stays set until the slot is released.
- R6: Writing to address 0 with data bit 16 set releases the slot. This zeroes the sequence number, the time register and status bits 16 to 19. A write to address 0 with bit 16 clear has no effect, and neither does a write to any other address.
- R7: In the transmit variant, a capture strobe on an empty slot stores the sequence number and sets the waiting flag (status bit 17). It also sets status bit 18 to the value of the request-source input, where 1 means software and 0 means hardware. The ready flag stays 0 and the time register is not changed.
- R8: In the transmit variant, a departure strobe while the waiting flag is set latches the time input, clears bit 17 and sets bit 16, all on the same clock edge.
- R9: A departure strobe that arrives while no capture is waiting changes nothing.
- R10: In the transmit variant, a capture strobe that arrives while the slot is waiting is discarded and sets the loss flag.
- R11: In the receive variant, status bits 17 and 18 always read 0. The departure strobe and the request-source input are ignored.
- R12: If a release write and a capture strobe fall on the same clock edge, the slot is emptied and then takes the new capture. The loss flag is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_stb | input | 1 | Capture request from the classifier |
| cap_sw | input | 1 | Request source for the capture: 1 for software, 0 for hardware |
| cap_seq | input | 16 | Sequence number of the event packet |
| tx_ts_stb | input | 1 | Departure strobe that completes a waiting capture |
| clk_now | input | 64 | Current time from the free-running counter |
| reg_addr | input | 2 | Register word address |
| reg_wr | input | 1 | Register write enable |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from the address |

## Verification
The internal state of the slot can be seen directly in the status word on the clock edge after any strobe.

A wrong acceptance decision shows up in the next read in one of three ways:
- a changed sequence number,
- a moved time value,
- a missing loss flag.

A waiting flag that never clears shows up as a ready flag that stays at 0 after the departure strobe. A release that is incomplete leaves nonzero status or time bits one cycle after the write.

The sweep runs both variants side by side on shared stimulus. In each iteration, every one of these facts is checked within one cycle of the event that causes it.

// File: rtl/ptp_ts_holdbuf.sv
module ptp_ts_holdbuf #(
  parameter int  SEQ_W   = 16,
  parameter int  TS_W    = 64,
  parameter int  RW      = 32,
  parameter int  AW      = 2,
  parameter bit  TX_MODE = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cap_stb,
  input  logic            cap_sw,
  input  logic [SEQ_W-1:0] cap_seq,
  input  logic            tx_ts_stb,
  input  logic [TS_W-1:0] clk_now,
  input  logic [AW-1:0]   reg_addr,
  input  logic            reg_wr,
  input  logic [RW-1:0]   reg_wdata,
  output logic [RW-1:0]   reg_rdata
);
  localparam int B_RDY  = SEQ_W;
  localparam int B_WAIT = SEQ_W + 1;
  localparam int B_SRC  = SEQ_W + 2;
  localparam int B_LOST = SEQ_W + 3;
  localparam int PAD_W  = RW - B_LOST - 1;
  localparam logic [AW-1:0] A_STAT = AW'(0);
  localparam logic [AW-1:0] A_LO   = AW'(1);
  localparam logic [AW-1:0] A_HI   = AW'(2);

  logic [SEQ_W-1:0] seq_q;
  logic [TS_W-1:0]  ts_q;
  logic             rdy_q, wait_q, src_q, lost_q;

  wire rel  = reg_wr && (reg_addr == A_STAT) && reg_wdata[B_RDY];
  wire busy = !rel && (rdy_q || wait_q);
  wire take = cap_stb && !busy;
  wire drop = cap_stb && busy;
  wire done = TX_MODE && tx_ts_stb && wait_q && !rel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq_q  <= '0;
      ts_q   <= '0;
      rdy_q  <= 1'b0;
      wait_q <= 1'b0;
      src_q  <= 1'b0;
      lost_q <= 1'b0;
    end else begin
      if (rel) begin
        seq_q  <= '0;
        ts_q   <= '0;
        rdy_q  <= 1'b0;
        wait_q <= 1'b0;
        src_q  <= 1'b0;
        lost_q <= 1'b0;
      end
      if (drop) lost_q <= 1'b1;
      if (take) begin
        seq_q <= cap_seq;
        if (TX_MODE) begin
          wait_q <= 1'b1;
          src_q  <= cap_sw;
        end else begin
          rdy_q <= 1'b1;
          ts_q  <= clk_now;
        end
      end
      if (done) begin
        wait_q <= 1'b0;
        rdy_q  <= 1'b1;
        ts_q   <= clk_now;
      end
    end
  end

  wire [RW-1:0] stat = {{PAD_W{1'b0}}, lost_q, src_q, wait_q, rdy_q, seq_q};

  always_comb begin
    case (reg_addr)
      A_STAT:  reg_rdata = stat;
      A_LO:    reg_rdata = ts_q[RW-1:0];
      A_HI:    reg_rdata = ts_q[TS_W-1:RW];
      default: reg_rdata = '0;
    endcase
  end

  // R8 R2
  one_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rdy_q && wait_q));

  // R4
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_stb && rdy_q && !rel) |=> ($stable(seq_q) && $stable(ts_q)));

  // R5 R10
  loss_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_stb && (rdy_q || wait_q) && !rel) |=> lost_q);

  // R5
  loss_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lost_q && !rel) |=> lost_q);

  // R8
  depart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_q && tx_ts_stb && !rel) |=> (rdy_q && !wait_q && ts_q == $past(clk_now)));

  // R6
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rel && !cap_stb) |=> (!rdy_q && !wait_q && !lost_q && ts_q == '0));

  // R11
  rx_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !TX_MODE |-> (!wait_q && !src_q));
endmodule

// File: tb/tb_ptp_ts_holdbuf.sv
`timescale 1ns/1ps
module tb_ptp_ts_holdbuf;
  logic clk = 0, rst_n = 0;
  logic cap_stb = 0, cap_sw = 0, tx_ts_stb = 0, reg_wr = 0;
  logic [15:0] cap_seq = '0;
  logic [63:0] clk_now = '0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] rd_tx, rd_rx;
  int vectors = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  ptp_ts_holdbuf #(.TX_MODE(1'b1)) dut (.clk, .rst_n, .cap_stb, .cap_sw, .cap_seq,
    .tx_ts_stb, .clk_now, .reg_addr, .reg_wr, .reg_wdata, .reg_rdata(rd_tx));
  ptp_ts_holdbuf #(.TX_MODE(1'b0)) dut_rx (.clk, .rst_n, .cap_stb, .cap_sw, .cap_seq,
    .tx_ts_stb, .clk_now, .reg_addr, .reg_wr, .reg_wdata, .reg_rdata(rd_rx));

  function automatic logic [31:0] st(bit lost, bit src, bit wt, bit rdy, logic [15:0] s);
    return {12'b0, lost, src, wt, rdy, s};
  endfunction

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic chk_both(string req, logic [31:0] ts_st, logic [63:0] ts_t,
                          logic [31:0] rx_st, logic [63:0] rx_t);
    reg_addr = 2'd0; #1;
    chk({req, " tx status"}, rd_tx, ts_st);
    chk({req, " rx status"}, rd_rx, rx_st);
    reg_addr = 2'd1; #1;
    chk({req, " tx time lo"}, rd_tx, ts_t[31:0]);
    chk({req, " rx time lo"}, rd_rx, rx_t[31:0]);
    reg_addr = 2'd2; #1;
    chk({req, " tx time hi"}, rd_tx, ts_t[63:32]);
    chk({req, " rx time hi"}, rd_rx, rx_t[63:32]);
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1; step(); reg_wr = 0;
  endtask

  initial begin
    step(); step();
    chk_both("R1 reset", '0, '0, '0, '0);
    rst_n = 1; step();
    reg_addr = 2'd3; #1;
    chk("R1 R3 addr3", rd_tx, '0);
    chk_both("R1 after reset", '0, '0, '0, '0);

    for (int i = 0; i < 64; i++) begin
      logic [15:0] s = 16'(i * 16'h0913 + 16'h00A5);
      bit sw = i[0];
      logic [63:0] t1 = 64'h0123_4567_89AB_CDEF ^ (64'(i) * 64'h0001_0003_0007_000F);
      logic [63:0] t2 = ~t1;
      cap_stb = 1; cap_seq = s; cap_sw = sw; clk_now = t1; step();
      cap_stb = 0; clk_now = t2;
      chk_both("R2 R7 capture", st(0, sw, 1, 0, s), '0, st(0, 0, 0, 1, s), t1);
      cap_stb = 1; cap_seq = ~s; cap_sw = ~sw; step(); cap_stb = 0;
      chk_both("R10 R4 drop while waiting", st(1, sw, 1, 0, s), '0, st(1, 0, 0, 1, s), t1);
      tx_ts_stb = 1; step(); tx_ts_stb = 0; clk_now = 64'hDEAD_BEEF_0BAD_F00D;
      chk_both("R8 R11 departure", st(1, sw, 0, 1, s), t2, st(1, 0, 0, 1, s), t1);
      cap_stb = 1; cap_seq = s ^ 16'h5A5A; tx_ts_stb = 1; step();
      cap_stb = 0; tx_ts_stb = 0;
      chk_both("R4 R5 R9 drop while ready", st(1, sw, 0, 1, s), t2, st(1, 0, 0, 1, s), t1);
      wr(2'd0, 32'hFFFE_FFFF);
      chk_both("R6 write bit16 clear", st(1, sw, 0, 1, s), t2, st(1, 0, 0, 1, s), t1);
      wr(2'd1, 32'hFFFF_FFFF);
      wr(2'd2, 32'hFFFF_FFFF);
      chk_both("R6 write other addr", st(1, sw, 0, 1, s), t2, st(1, 0, 0, 1, s), t1);
      if (i % 8 == 0) begin
        reg_addr = 2'd3; #1;
        chk("R3 addr3 zero", rd_tx, '0);
      end
      wr(2'd0, 32'h0001_0000);
      chk_both("R6 release", '0, '0, '0, '0);
      tx_ts_stb = 1; step(); tx_ts_stb = 0;
      chk_both("R9 departure on empty", '0, '0, '0, '0);
    end

    cap_stb = 1; cap_seq = 16'h1111; cap_sw = 1; clk_now = 64'h0000_0001_0000_0002; step();
    cap_stb = 0;
    tx_ts_stb = 1; clk_now = 64'h0000_0003_0000_0004; step(); tx_ts_stb = 0;
    reg_addr = 2'd0; reg_wdata = 32'h0001_0000; reg_wr = 1;
    cap_stb = 1; cap_seq = 16'h2222; cap_sw = 0; clk_now = 64'h0000_0005_0000_0006; step();
    reg_wr = 0; cap_stb = 0;
    chk_both("R12 release with capture", st(0, 0, 1, 0, 16'h2222), '0,
             st(0, 0, 0, 1, 16'h2222), 64'h0000_0005_0000_0006);

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!finished) begin
      finished = 1;
      vectors++; errors++;
      $display("FAIL watchdog got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule